// File: doc/BRIEF.md
# Bus Interrupter with Acknowledge Daisy-Chain

This block sits between four local interrupting devices and a system bus that carries seven prioritised, active-low interrupt request lines. Software programs each local source through a small host port. Each source has a control register that holds its enable, request level, response mode, flag and flag auto-clear bits, and a vector register. Once a device raises its input, the block records a pending request. While the request stays enabled it pulls down the bus request line for the programmed level.

When the bus runs an interrupt-acknowledge cycle, the acknowledged level appears on the address lines and the acknowledge-in input of the daisy chain is low. If the block has a pending source at that level, it claims the cycle. In internal mode it returns the stored vector with a data-acknowledge pulse. In external mode it pulses a local acknowledge naming the source, and the device supplies the vector itself. With nothing pending at that level, the block passes the acknowledge on to the next device in the chain. Pad drivers are outside this block, so every bus output is modelled as active-low logic.

Top module: `bus_irq_daisy`

## Requirements
- R1: A host access (cs_n low, iack_n high) to address index 0..3 reaches control register 0..3, and index 4..7 reaches vector register 0..3. Each chip-select assertion produces exactly one dtack_n low pulse of one cycle, one cycle after the access is sampled. Read data is valid during that pulse.
- R2: Control register layout: bits 2..0 hold the request level, bit 3 selects external mode (1), bit 4 is the enable, bit 5 is the flag and bit 6 is the flag auto-clear. Bit 7 always reads 0. Vector registers read back exactly what was written.
- R3: A source becomes pending when its input is high at a clock edge while its enable is set. A pending, enabled source with level L (1..7) drives irq_n bit L-1 low. An input that rises while the enable is clear leaves every request line high.
- R4: A source programmed to level 0 drives no request line, even when it is pending.
- R5: When several sources are pending at the same level, that request line stays low until one acknowledge has been made for each of them.
- R6: In an acknowledge cycle, the lowest-numbered pending source whose level equals addr wins, and its pending request is cleared.
- R7: In internal mode (bit 3 = 0), the winner's vector appears on rdata together with a one-cycle dtack_n low pulse, one cycle after the acknowledge is sampled.
- R8: In external mode (bit 3 = 1), the winner produces a one-cycle lack_n low pulse with lack_id equal to its index. dtack_n stays high.
- R9: With no pending source at the acknowledged level, ack_out_n goes low one cycle after the acknowledge is sampled and stays low until one cycle after iack_n rises. No dtack_n or lack_n pulse is produced, and other pending requests are unaffected.
- R10: While ack_in_n is high, an acknowledge cycle is ignored: no response, no pass-through, and no pending request is cleared.
- R11: When a source is acknowledged, its flag is set if auto-clear is 0 and cleared if auto-clear is 1. Software can also write the flag.
- R12: After reset, all request lines, dtack_n, lack_n and ack_out_n are high, and all registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 3 | Register index; acknowledged level during acknowledge |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data or vector |
| dtack_n | output | 1 | Data acknowledge pulse, active low |
| dev_irq | input | 4 | Local device requests, active high |
| irq_n | output | 7 | Bus requests, bit k = level k+1, active low |
| iack_n | input | 1 | Acknowledge cycle in progress, active low |
| ack_in_n | input | 1 | Daisy-chain acknowledge in, active low |
| ack_out_n | output | 1 | Daisy-chain acknowledge out, active low |
| lack_n | output | 1 | Local acknowledge pulse for external mode, active low |
| lack_id | output | 2 | Index of the locally acknowledged source |

## Verification
The hardest situation to reach is an acknowledge at a level shared by two pending sources. Here the request line must stay low after the first acknowledge and rise only after the second, and the two vectors must come back in index order. The bench reaches it by programming two sources to the same level and pulsing their inputs in reverse index order before the first acknowledge. It then acknowledges twice and checks the vector and the request line after each cycle. It also creates a miss that is not trivial: one source is left pending at another level while an unmatched level is acknowledged. This shows that the pass-through does not disturb that source.

// File: rtl/bid_pkg.sv
// Shared sizing and control-register bit positions for the bus interrupter.
// Assumes an 8-bit or wider data bus and a 3-bit request level.
package bid_pkg;
    localparam int NSRC_DEF = 4;
    localparam int LW_DEF   = 3;
    localparam int DW_DEF   = 8;
    localparam int CB_EXT   = 3;
    localparam int CB_IE    = 4;
    localparam int CB_FLAG  = 5;
    localparam int CB_AC    = 6;
endpackage

// File: rtl/bid_regs.sv
// Register file and host port: per-source control fields and vectors.
// Assumes host accesses only occur while no acknowledge cycle is active.
module bid_regs #(
    parameter int NSRC = bid_pkg::NSRC_DEF,
    parameter int LW   = bid_pkg::LW_DEF,
    parameter int DW   = bid_pkg::DW_DEF,
    localparam int AW  = $clog2(2 * NSRC),
    localparam int IW  = $clog2(NSRC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n,
    input  logic                      rd_wr,
    input  logic [AW-1:0]             addr,
    input  logic [DW-1:0]             wdata,
    input  logic                      iack_n,
    input  logic                      ack_hit,
    input  logic [IW-1:0]             ack_idx,
    output logic [DW-1:0]             rdata_h,
    output logic                      dtack_h,
    output logic [NSRC-1:0][LW-1:0]   lvl,
    output logic [NSRC-1:0]           ie,
    output logic [NSRC-1:0]           ext,
    output logic [NSRC-1:0][DW-1:0]   vec
);
    logic [NSRC-1:0] flag_q, ac_q;
    logic            hdone_q;
    logic            sel_vec;
    logic [AW-1:0]   off;
    logic [IW-1:0]   idx;
    logic [DW-1:0]   cr_rd;

    // Decode the register index into a bank select and a source index.
    always_comb begin
        sel_vec = (addr >= AW'(NSRC));
        off     = sel_vec ? addr - AW'(NSRC) : addr;
        idx     = off[IW-1:0];
        cr_rd   = '0;
        cr_rd[LW-1:0]  = lvl[idx];
        cr_rd[bid_pkg::CB_EXT]  = ext[idx];
        cr_rd[bid_pkg::CB_IE]   = ie[idx];
        cr_rd[bid_pkg::CB_FLAG] = flag_q[idx];
        cr_rd[bid_pkg::CB_AC]   = ac_q[idx];
    end

    // Serve one host access per chip-select assertion and apply flag updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl <= '0; ie <= '0; ext <= '0; vec <= '0;
            flag_q <= '0; ac_q <= '0;
            hdone_q <= 1'b0; dtack_h <= 1'b0; rdata_h <= '0;
        end else begin
            dtack_h <= 1'b0;
            if (cs_n) begin
                hdone_q <= 1'b0;
            end else if (!hdone_q && iack_n) begin
                hdone_q <= 1'b1;
                dtack_h <= 1'b1;
                if (rd_wr) begin
                    rdata_h <= sel_vec ? vec[idx] : cr_rd;
                end else if (sel_vec) begin
                    vec[idx] <= wdata;
                end else begin
                    lvl[idx]    <= wdata[LW-1:0];
                    ext[idx]    <= wdata[bid_pkg::CB_EXT];
                    ie[idx]     <= wdata[bid_pkg::CB_IE];
                    flag_q[idx] <= wdata[bid_pkg::CB_FLAG];
                    ac_q[idx]   <= wdata[bid_pkg::CB_AC];
                end
            end
            if (ack_hit) flag_q[ack_idx] <= !ac_q[ack_idx];
        end
    end

    // R1
    host_dtack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dtack_h |=> !dtack_h);
endmodule

// File: rtl/bid_reqmap.sv
// Pending latches per source and mapping of enabled requests onto levels.
// Assumes clr is one-hot or zero and comes from the acknowledge controller.
module bid_reqmap #(
    parameter int NSRC = bid_pkg::NSRC_DEF,
    parameter int LW   = bid_pkg::LW_DEF,
    localparam int NLVL = (1 << LW) - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSRC-1:0]         dev_irq,
    input  logic [NSRC-1:0]         ie,
    input  logic [NSRC-1:0][LW-1:0] lvl,
    input  logic [NSRC-1:0]         clr,
    output logic [NSRC-1:0]         active,
    output logic [NLVL-1:0]         irq_n
);
    logic [NSRC-1:0] pend_q;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        // Capture an enabled request; an acknowledge clears it first.
        always_ff @(posedge clk) begin
            if (!rst_n)                   pend_q[g] <= 1'b0;
            else if (clr[g])              pend_q[g] <= 1'b0;
            else if (dev_irq[g] && ie[g]) pend_q[g] <= 1'b1;
        end
        assign active[g] = pend_q[g] && ie[g] && (lvl[g] != '0);

        // R6
        pend_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clr[g] |=> !pend_q[g]);
    end

    for (genvar k = 1; k <= NLVL; k++) begin : g_lvl
        // Pull level k low while any active source is programmed to it.
        always_comb begin
            irq_n[k-1] = 1'b1;
            for (int s = 0; s < NSRC; s++)
                if (active[s] && lvl[s] == LW'(k)) irq_n[k-1] = 1'b0;
        end
    end
endmodule

// File: rtl/bid_ackctl.sv
// Acknowledge controller: picks the lowest-index pending source at the
// acknowledged level, answers once per cycle, else passes the chain on.
// Assumes iack_n stays low for the whole acknowledge cycle.
module bid_ackctl #(
    parameter int NSRC = bid_pkg::NSRC_DEF,
    parameter int LW   = bid_pkg::LW_DEF,
    parameter int DW   = bid_pkg::DW_DEF,
    localparam int IW  = $clog2(NSRC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    iack_n,
    input  logic                    ack_in_n,
    input  logic [LW-1:0]           ack_lvl,
    input  logic [NSRC-1:0]         active,
    input  logic [NSRC-1:0][LW-1:0] lvl,
    input  logic [NSRC-1:0]         ext,
    input  logic [NSRC-1:0][DW-1:0] vec,
    output logic [NSRC-1:0]         clr,
    output logic                    hit,
    output logic [IW-1:0]           win,
    output logic                    dtack_a,
    output logic [DW-1:0]           rdata_a,
    output logic                    lack_q,
    output logic [IW-1:0]           lack_id,
    output logic                    pass_q
);
    logic [NSRC-1:0] match;
    logic            done_q, start, any;

    // Find the lowest-numbered matching source and form the clear strobe.
    always_comb begin
        win = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            match[i] = active[i] && (lvl[i] == ack_lvl);
            if (match[i]) win = IW'(i);
        end
        any   = |match;
        start = !iack_n && !ack_in_n && !done_q;
        hit   = start && any;
        clr   = hit ? (NSRC'(1) << win) : '0;
    end

    // Answer one acknowledge per cycle, or hold the chain pass-through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0; pass_q <= 1'b0; dtack_a <= 1'b0; lack_q <= 1'b0;
            rdata_a <= '0; lack_id <= '0;
        end else begin
            dtack_a <= 1'b0;
            lack_q  <= 1'b0;
            if (iack_n) begin
                done_q <= 1'b0;
                pass_q <= 1'b0;
            end else if (start) begin
                done_q <= 1'b1;
                if (!any) begin
                    pass_q <= 1'b1;
                end else if (ext[win]) begin
                    lack_q  <= 1'b1;
                    lack_id <= win;
                end else begin
                    dtack_a <= 1'b1;
                    rdata_a <= vec[win];
                end
            end
        end
    end

    // R6
    clr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr));
    // R7
    vec_dtack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dtack_a |=> !dtack_a);
    // R8
    one_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dtack_a, lack_q}));
    // R9
    pass_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pass_q |-> !(dtack_a || lack_q));
    // R10
    chain_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_in_n |=> !(dtack_a || lack_q));
endmodule

// File: rtl/bus_irq_daisy.sv
// Top of the bus interrupter: host register port, request mapping and
// daisy-chained acknowledge handling. All bus outputs are active-low logic.
module bus_irq_daisy #(
    parameter int NSRC = bid_pkg::NSRC_DEF,
    parameter int LW   = bid_pkg::LW_DEF,
    parameter int DW   = bid_pkg::DW_DEF,
    localparam int AW   = $clog2(2 * NSRC),
    localparam int IW   = $clog2(NSRC),
    localparam int NLVL = (1 << LW) - 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            rd_wr,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic            dtack_n,
    input  logic [NSRC-1:0] dev_irq,
    output logic [NLVL-1:0] irq_n,
    input  logic            iack_n,
    input  logic            ack_in_n,
    output logic            ack_out_n,
    output logic            lack_n,
    output logic [IW-1:0]   lack_id
);
    logic [NSRC-1:0][LW-1:0] lvl;
    logic [NSRC-1:0][DW-1:0] vec;
    logic [NSRC-1:0]         ie, ext, active, clr;
    logic                    hit, dtack_h, dtack_a, lack_q, pass_q;
    logic [IW-1:0]           win;
    logic [DW-1:0]           rdata_h, rdata_a;

    bid_regs #(.NSRC(NSRC), .LW(LW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr(rd_wr), .addr(addr),
        .wdata(wdata), .iack_n(iack_n), .ack_hit(hit), .ack_idx(win),
        .rdata_h(rdata_h), .dtack_h(dtack_h), .lvl(lvl), .ie(ie), .ext(ext),
        .vec(vec));

    bid_reqmap #(.NSRC(NSRC), .LW(LW)) u_map (
        .clk(clk), .rst_n(rst_n), .dev_irq(dev_irq), .ie(ie), .lvl(lvl),
        .clr(clr), .active(active), .irq_n(irq_n));

    bid_ackctl #(.NSRC(NSRC), .LW(LW), .DW(DW)) u_ack (
        .clk(clk), .rst_n(rst_n), .iack_n(iack_n), .ack_in_n(ack_in_n),
        .ack_lvl(addr[LW-1:0]), .active(active), .lvl(lvl), .ext(ext),
        .vec(vec), .clr(clr), .hit(hit), .win(win), .dtack_a(dtack_a),
        .rdata_a(rdata_a), .lack_q(lack_q), .lack_id(lack_id),
        .pass_q(pass_q));

    // Merge the two acknowledge sources onto the shared data port.
    assign dtack_n   = !(dtack_h || dtack_a);
    assign rdata     = dtack_a ? rdata_a : rdata_h;
    assign lack_n    = !lack_q;
    assign ack_out_n = !pass_q;

    // R1
    dtack_src_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dtack_h && dtack_a));
endmodule

// File: tb/tb_bus_irq_daisy.sv
module tb_bus_irq_daisy;
    logic       clk = 1'b0, rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_wr = 1'b1, iack_n = 1'b1, ack_in_n = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic [3:0] dev_irq = '0;
    logic [6:0] irq_n;
    logic       dtack_n, ack_out_n, lack_n;
    logic [1:0] lack_id;
    int         errs = 0, checks = 0;

    always #2 clk = !clk;

    bus_irq_daisy dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_wr(rd_wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .dtack_n(dtack_n), .dev_irq(dev_irq),
        .irq_n(irq_n), .iack_n(iack_n), .ack_in_n(ack_in_n),
        .ack_out_n(ack_out_n), .lack_n(lack_n), .lack_id(lack_id));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Host access; also checks that dtack_n is a single pulse (R1).
    task automatic host(input bit rd, input logic [2:0] a, input logic [7:0] d,
                        output logic [7:0] q);
        int n = 0;
        @(negedge clk);
        cs_n = 1'b0; rd_wr = rd; addr = a; wdata = d;
        do begin @(negedge clk); n++; end while (dtack_n && n < 10);
        chk(n == 1, "R1 dtack latency", n, 1);
        q = rdata;
        @(negedge clk);
        chk(dtack_n, "R1 single dtack", dtack_n, 1);
        cs_n = 1'b1; rd_wr = 1'b1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        logic [7:0] q;
        host(1'b0, a, d, q);
    endtask

    task automatic pulse(input logic [3:0] m);
        @(negedge clk); dev_irq = m;
        @(negedge clk); dev_irq = '0;
    endtask

    // One acknowledge cycle at level lv; samples one cycle after it starts.
    task automatic ack(input logic [2:0] lv, input bit chain, output logic dt,
                       output logic [7:0] rd, output logic la,
                       output logic [1:0] lid, output logic ao);
        @(negedge clk);
        iack_n = 1'b0; ack_in_n = !chain; addr = lv;
        @(negedge clk);
        dt = dtack_n; rd = rdata; la = lack_n; lid = lack_id; ao = ack_out_n;
        @(negedge clk);
        iack_n = 1'b1; ack_in_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] q;
        chk(irq_n == 7'h7F, "R12 irq idle", irq_n, 7'h7F);
        chk(dtack_n && lack_n && ack_out_n, "R12 strobes idle",
            {dtack_n, lack_n, ack_out_n}, 3'b111);
        host(1'b1, 3'd0, 8'h00, q);
        chk(q == 8'h00, "R12 CR0 reset", q, 0);
    endtask

    task automatic t_regs();
        logic [7:0] q;
        wr(3'd2, 8'hFF);
        host(1'b1, 3'd2, 8'h00, q);
        chk(q == 8'h7F, "R2 CR bit7 reads zero", q, 8'h7F);
        wr(3'd7, 8'hA5);
        host(1'b1, 3'd7, 8'h00, q);
        chk(q == 8'hA5, "R1 VR3 readback", q, 8'hA5);
        wr(3'd2, 8'h00);
        wr(3'd7, 8'h00);
    endtask

    task automatic t_map_flag();
        logic dt, la, ao; logic [7:0] rd, q; logic [1:0] lid;
        wr(3'd0, 8'h13); wr(3'd4, 8'h40);
        pulse(4'b0001);
        chk(irq_n == 7'h7B, "R3 level 3 request", irq_n, 7'h7B);
        wr(3'd1, 8'h10);
        pulse(4'b0010);
        chk(irq_n == 7'h7B, "R4 level zero silent", irq_n, 7'h7B);
        wr(3'd2, 8'h06);
        pulse(4'b0100);
        chk(irq_n == 7'h7B, "R3 disabled source silent", irq_n, 7'h7B);
        ack(3'd3, 1'b1, dt, rd, la, lid, ao);
        chk(!dt && rd == 8'h40, "R7 internal vector", rd, 8'h40);
        chk(irq_n == 7'h7F, "R6 request cleared", irq_n, 7'h7F);
        host(1'b1, 3'd0, 8'h00, q);
        chk(q == 8'h33, "R11 flag set on ack", q, 8'h33);
        wr(3'd0, 8'h73);
        pulse(4'b0001);
        ack(3'd3, 1'b1, dt, rd, la, lid, ao);
        host(1'b1, 3'd0, 8'h00, q);
        chk(q == 8'h53, "R11 auto-clear", q, 8'h53);
        wr(3'd0, 8'h13);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_shared();
        logic dt, la, ao; logic [7:0] rd; logic [1:0] lid;
        wr(3'd1, 8'h15); wr(3'd2, 8'h15); wr(3'd5, 8'h11); wr(3'd6, 8'h22);
        pulse(4'b0100);
        pulse(4'b0010);
        chk(irq_n == 7'h6F, "R5 shared level 5", irq_n, 7'h6F);
        ack(3'd5, 1'b1, dt, rd, la, lid, ao);
        chk(!dt && rd == 8'h11, "R6 lowest index wins", rd, 8'h11);
        chk(irq_n == 7'h6F, "R5 still asserted", irq_n, 7'h6F);
        ack(3'd5, 1'b1, dt, rd, la, lid, ao);
        chk(!dt && rd == 8'h22, "R7 second vector", rd, 8'h22);
        chk(irq_n == 7'h7F, "R5 released", irq_n, 7'h7F);
        wr(3'd1, 8'h00); wr(3'd2, 8'h00);
    endtask

    task automatic t_pass_gate();
        logic dt, la, ao; logic [7:0] rd; logic [1:0] lid;
        pulse(4'b0001);
        ack(3'd4, 1'b1, dt, rd, la, lid, ao);
        chk(!ao && dt && la, "R9 pass-through", {ao, dt, la}, 3'b011);
        chk(ack_out_n, "R9 pass released", ack_out_n, 1);
        chk(irq_n == 7'h7B, "R9 other level kept", irq_n, 7'h7B);
        ack(3'd3, 1'b0, dt, rd, la, lid, ao);
        chk(dt && la && ao, "R10 gated ack silent", {dt, la, ao}, 3'b111);
        chk(irq_n == 7'h7B, "R10 request kept", irq_n, 7'h7B);
        ack(3'd3, 1'b1, dt, rd, la, lid, ao);
        chk(irq_n == 7'h7F, "R6 cleared after gate", irq_n, 7'h7F);
    endtask

    task automatic t_ext();
        logic dt, la, ao; logic [7:0] rd; logic [1:0] lid;
        wr(3'd3, 8'h1F);
        pulse(4'b1000);
        chk(irq_n == 7'h3F, "R3 level 7 request", irq_n, 7'h3F);
        ack(3'd7, 1'b1, dt, rd, la, lid, ao);
        chk(!la && lid == 2'd3 && dt, "R8 external ack", {la, lid, dt}, 4'b0111);
        chk(irq_n == 7'h7F, "R8 request cleared", irq_n, 7'h7F);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_map_flag();
        t_shared();
        t_pass_gate();
        t_ext();
        finish_run();
    end

    initial begin
        #400000;
        checks++; errs++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        finish_run();
    end
endmodule